// File: doc/BRIEF.md
# Multi-Channel Reloading Interval Timer

This block holds a set of identical down-counting interval timers behind a small register port. Each channel keeps a reload register and a read-only count word. The reload register holds a 31-bit reload value and a stop bit. The count word holds the running 31-bit count and a status bit that flips on every reload. Counting advances on a prescaled enable pulse, `tick_i`. When a running channel goes from one to zero, it restarts from its reload value, flips its status bit and, unless masked, raises a one-cycle interrupt pulse on its own line.

Software programs a channel by writing its reload register. It holds a channel with the stop bit and restarts it by clearing that bit. It polls progress by reading the count word. Interrupt prioritisation, vector delivery and the bus bridge sit outside this block.

Top module: `ivt_bank`

## Requirements
- R1: After a synchronous reset every count word, every reload register, `rdata_o` and `irq_o` are all zero.
- R2: Byte addresses use a 0x40 stride per channel. The count word of channel c sits at c*0x40+0x00 and the reload register at c*0x40+0x10. A read of any other offset returns zero. `rdata_o` shows the value one cycle after the `rd_en_i` cycle and holds it while `rd_en_i` is low.
- R3: The reload register reads back exactly as written: bit 31 is the stop bit and bits 30..0 are the reload value.
- R4: A write to a count-word address changes nothing.
- R5: With the stop bit at 0, the count drops by one on each cycle in which `tick_i` is high, and stays unchanged on cycles without a tick.
- R6: While the stop bit is 1, the count word holds its value whatever `tick_i` does.
- R7: When the stop bit changes from 1 to 0, the count loads the reload value in the cycle after the write, whether or not a tick is present. The count decrements on the ticks after that.
- R8: A tick on a running channel whose count is zero and whose reload value is nonzero loads the reload value, with no status flip and no interrupt.
- R9: A tick on a running channel whose count is one reloads the count from the reload value and inverts the status bit (bit 31 of the count word).
- R10: `irq_o[c]` is high for exactly the one cycle in which the reloaded count first appears, and only if `irq_mask_i[c]` was 0 at the tick. A masked channel still reloads and flips its status bit.
- R11: A reload value of zero leaves the channel idle: no reload, no status flip and no interrupt. A count already running steps down to zero and stays there.
- R12: If a reload-register write lands in the same cycle as a reload tick, the reload uses the value held before the write. The new value takes effect at the next reload.
- R13: Channels are independent: ticks, writes and stops on one channel never change another channel's count word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Prescaled count enable, one cycle per step |
| irq_mask_i | input | NCH | Per-channel interrupt mask, 1 suppresses the pulse |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address (channel index above the stride bits) |
| wdata_i | input | CNT_W+1 | Write data |
| rdata_o | output | CNT_W+1 | Registered read data |
| irq_o | output | NCH | Per-channel one-cycle reload interrupt |

## Verification
Two pairs of functions can fall in the same cycle. A software write to the reload register can coincide with a reload tick. A stop-bit release can coincide with a tick, and there the load of the reload value must win over a decrement. The bench drives a reload-register write and `tick_i` in the same cycle on a channel whose count is one. It then judges that the count returns the old reload value with the status bit flipped and the interrupt raised, and that the new value appears only at the following reload. It also releases the stop bit while `tick_i` is high and expects the full reload value rather than one less.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  // Offsets inside one channel's address window
  localparam int unsigned OFS_COUNT  = 'h00;
  localparam int unsigned OFS_RELOAD = 'h10;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_RELOAD = 2'd2
  } regsel_e;
endpackage

// File: rtl/ivt_regif.sv
module ivt_regif
  import ivt_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int STRIDE_LG = 6,
  localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W   = CH_W + STRIDE_LG
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  output logic [CH_W-1:0]   ch_o,
  output regsel_e           sel_o,
  output logic [NCH-1:0]    reload_we_o
);
  logic [STRIDE_LG-1:0] ofs;
  logic                 ch_ok;

  always_comb begin
    ch_o  = addr_i[ADDR_W-1:STRIDE_LG];
    ofs   = addr_i[STRIDE_LG-1:0];
    ch_ok = (32'(ch_o) < 32'(NCH));
    if (!ch_ok)
      sel_o = SEL_NONE;
    else if (ofs == STRIDE_LG'(OFS_COUNT))
      sel_o = SEL_COUNT;
    else if (ofs == STRIDE_LG'(OFS_RELOAD))
      sel_o = SEL_RELOAD;
    else
      sel_o = SEL_NONE;
  end

  // Count words are read-only: only the reload register gets a write enable
  for (genvar g = 0; g < NCH; g++) begin : g_we
    assign reload_we_o[g] = wr_en_i && (sel_o == SEL_RELOAD) && (ch_o == CH_W'(g));
  end
endmodule

// File: rtl/ivt_chan.sv
module ivt_chan #(
  parameter int CNT_W = 31,
  localparam int DW   = CNT_W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          mask_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] count_o,
  output logic [DW-1:0] reload_o,
  output logic          irq_o
);
  logic [CNT_W-1:0] cnt_q, rld_q;
  logic             flip_q, stop_q, stop_d_q, irq_q;
  logic             release_w, at_zero, at_one, rld_nz;

  assign release_w = stop_d_q & ~stop_q;
  assign at_zero   = (cnt_q == '0);
  assign at_one    = (cnt_q == CNT_W'(1));
  assign rld_nz    = (rld_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      rld_q    <= '0;
      flip_q   <= 1'b0;
      stop_q   <= 1'b0;
      stop_d_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q    <= 1'b0;
      stop_d_q <= stop_q;
      if (we_i) begin
        stop_q <= wdata_i[DW-1];
        rld_q  <= wdata_i[CNT_W-1:0];
      end
      if (release_w) begin
        cnt_q <= rld_q;
      end else if (tick_i && !stop_q) begin
        if (at_zero) begin
          if (rld_nz) cnt_q <= rld_q;
        end else if (at_one) begin
          cnt_q <= rld_q;
          if (rld_nz) begin
            flip_q <= ~flip_q;
            irq_q  <= ~mask_i;
          end
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign count_o  = {flip_q, cnt_q};
  assign reload_o = {stop_q, rld_q};
  assign irq_o    = irq_q;
endmodule

// File: rtl/ivt_rdport.sv
module ivt_rdport
  import ivt_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int DW   = 32,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en_i,
  input  logic [CH_W-1:0]        ch_i,
  input  regsel_e                sel_i,
  input  logic [NCH-1:0][DW-1:0] count_i,
  input  logic [NCH-1:0][DW-1:0] reload_i,
  output logic [DW-1:0]          rdata_o
);
  logic [DW-1:0] nxt;

  always_comb begin
    unique case (sel_i)
      SEL_COUNT:  nxt = count_i[ch_i];
      SEL_RELOAD: nxt = reload_i[ch_i];
      default:    nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= nxt;
  end
endmodule

// File: rtl/ivt_bank.sv
module ivt_bank
  import ivt_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int CNT_W     = 31,
  parameter int STRIDE_LG = 6,
  localparam int DW       = CNT_W + 1,
  localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W   = CH_W + STRIDE_LG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [NCH-1:0]    irq_mask_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NCH-1:0]    irq_o
);
  logic [CH_W-1:0]        ch_w;
  regsel_e                sel_w;
  logic [NCH-1:0]         we_w;
  logic [NCH-1:0][DW-1:0] count_w;
  logic [NCH-1:0][DW-1:0] reload_w;

  ivt_regif #(.NCH(NCH), .STRIDE_LG(STRIDE_LG)) u_regif (
    .addr_i      (addr_i),
    .wr_en_i     (wr_en_i),
    .ch_o        (ch_w),
    .sel_o       (sel_w),
    .reload_we_o (we_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ivt_chan #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .tick_i   (tick_i),
      .mask_i   (irq_mask_i[g]),
      .we_i     (we_w[g]),
      .wdata_i  (wdata_i),
      .count_o  (count_w[g]),
      .reload_o (reload_w[g]),
      .irq_o    (irq_o[g])
    );
  end

  ivt_rdport #(.NCH(NCH), .DW(DW)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en_i  (rd_en_i),
    .ch_i     (ch_w),
    .sel_i    (sel_w),
    .count_i  (count_w),
    .reload_i (reload_w),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/ivt_bank_chk.sv
module ivt_bank_chk #(
  parameter int NCH   = 4,
  parameter int CNT_W = 31,
  localparam int DW   = CNT_W + 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   tick_i,
  input logic [NCH-1:0]         irq_mask_i,
  input logic [NCH-1:0]         irq_o,
  input logic [NCH-1:0][DW-1:0] count_w,
  input logic [NCH-1:0][DW-1:0] reload_w
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
      irq_o[i] |-> $past(tick_i && !irq_mask_i[i]));

    // R9
    irq_flip_chk: assert property (@(posedge clk) disable iff (rst)
      irq_o[i] |-> (count_w[i][DW-1] != $past(count_w[i][DW-1])));

    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
      reload_w[i][DW-1] |=> $stable(count_w[i]));

    // R5
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!tick_i && (reload_w[i][DW-1] == $past(reload_w[i][DW-1])))
        |=> $stable(count_w[i]));

    // R11
    zero_reload_chk: assert property (@(posedge clk) disable iff (rst)
      irq_o[i] |-> ($past(reload_w[i][CNT_W-1:0]) != '0));
  end
endmodule

bind ivt_bank ivt_bank_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick_i     (tick_i),
  .irq_mask_i (irq_mask_i),
  .irq_o      (irq_o),
  .count_w    (count_w),
  .reload_w   (reload_w)
);

// File: tb/ivt_bank_test.sv
module ivt_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [3:0]  mask = 4'b0000;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  int          nchk = 0;
  int          nerr = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ivt_bank uut (
    .clk(clk), .rst(rst), .tick_i(tick), .irq_mask_i(mask),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic        tk;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
    logic [3:0]  eirq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0,8'h00,32'h0,32'h0,4'h0,4'd1},           // R1 count word 0
    '{1'b0,1'b1,1'b0,8'h10,32'h0,32'h0,4'h0,4'd1},           // R1 reload reg 0
    '{1'b1,1'b0,1'b0,8'h10,32'h3,32'h0,4'h0,4'd3},           // R3 write reload 3
    '{1'b0,1'b1,1'b0,8'h10,32'h0,32'h3,4'h0,4'd3},           // R3 readback
    '{1'b0,1'b0,1'b1,8'h00,32'h0,32'h0,4'h0,4'd8},           // R8 first load, no irq
    '{1'b0,1'b1,1'b0,8'h00,32'h0,32'h3,4'h0,4'd8},           // R8
    '{1'b0,1'b0,1'b1,8'h00,32'h0,32'h0,4'h0,4'd5},           // R5 3->2
    '{1'b0,1'b0,1'b1,8'h00,32'h0,32'h0,4'h0,4'd5},           // R5 2->1
    '{1'b0,1'b1,1'b0,8'h00,32'h0,32'h1,4'h0,4'd5},           // R5
    '{1'b0,1'b0,1'b1,8'h00,32'h0,32'h0,4'h1,4'd9},           // R9 reload, irq
    '{1'b0,1'b1,1'b0,8'h00,32'h0,32'h8000_0003,4'h0,4'd9},   // R9 status flipped
    '{1'b1,1'b0,1'b0,8'h00,32'h1234,32'h0,4'h0,4'd4},        // R4 write count word
    '{1'b0,1'b1,1'b0,8'h00,32'h0,32'h8000_0003,4'h0,4'd4},   // R4 unchanged
    '{1'b0,1'b1,1'b0,8'h04,32'h0,32'h0,4'h0,4'd2},           // R2 unused offset
    '{1'b1,1'b0,1'b0,8'h10,32'h8000_0005,32'h0,4'h0,4'd6},   // R6 stop
    '{1'b0,1'b0,1'b1,8'h00,32'h0,32'h0,4'h0,4'd6},           // R6 tick ignored
    '{1'b0,1'b1,1'b0,8'h00,32'h0,32'h8000_0003,4'h0,4'd6},   // R6 held
    '{1'b1,1'b0,1'b0,8'h10,32'h5,32'h0,4'h0,4'd7},           // R7 release
    '{1'b0,1'b0,1'b1,8'h00,32'h0,32'h0,4'h0,4'd7},           // R7 load beats tick
    '{1'b0,1'b1,1'b0,8'h00,32'h0,32'h8000_0005,4'h0,4'd7},   // R7
    '{1'b0,1'b0,1'b1,8'h00,32'h0,32'h0,4'h0,4'd5},           // R5 5->4
    '{1'b0,1'b1,1'b0,8'h00,32'h0,32'h8000_0004,4'h0,4'd5},   // R5
    '{1'b1,1'b0,1'b0,8'h10,32'h8000_0004,32'h0,4'h0,4'd6}    // R6 park channel 0
  };

  task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL R%0d got %h exp %h", req, got, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic t,
                      input logic [7:0] a, input logic [31:0] d);
    wr_en = w; rd_en = r; tick = t; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd_chk(input int req, input logic [7:0] a, input logic [31:0] exp);
    step(1'b0, 1'b1, 1'b0, a, 32'h0);
    chk(req, rdata, exp);
  endtask

  task automatic tick_chk(input int req, input logic [3:0] eirq);
    step(1'b0, 1'b0, 1'b1, 8'h00, 32'h0);
    chk(req, {28'h0, irq}, {28'h0, eirq});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog got timeout exp completion");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 outputs after reset
    chk(1, {28'h0, irq}, 32'h0);
    chk(1, rdata, 32'h0);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k].wr, VEC[k].rd, VEC[k].tk, VEC[k].a, VEC[k].d);
      chk(int'(VEC[k].req), {28'h0, irq}, {28'h0, VEC[k].eirq});
      if (VEC[k].rd) chk(int'(VEC[k].req), rdata, VEC[k].exp);
    end

    // R10 masked reload on channel 1
    mask = 4'b0010;
    step(1'b1, 1'b0, 1'b0, 8'h50, 32'h2);
    tick_chk(8, 4'h0);
    tick_chk(5, 4'h0);
    tick_chk(10, 4'h0);
    rd_chk(10, 8'h40, 32'h8000_0002);
    mask = 4'b0000;
    tick_chk(5, 4'h0);
    tick_chk(10, 4'b0010);
    step(1'b0, 1'b0, 1'b0, 8'h00, 32'h0);
    chk(10, {28'h0, irq}, 32'h0);   // R10 single cycle
    rd_chk(9, 8'h40, 32'h0000_0002);
    // R2 rdata holds without a read strobe
    step(1'b0, 1'b0, 1'b0, 8'h10, 32'h0);
    step(1'b0, 1'b0, 1'b0, 8'h10, 32'h0);
    chk(2, rdata, 32'h0000_0002);
    step(1'b1, 1'b0, 1'b0, 8'h50, 32'h8000_0002);

    // R12 reload-register write collides with reload tick on channel 2
    step(1'b1, 1'b0, 1'b0, 8'h90, 32'h2);
    tick_chk(8, 4'h0);
    tick_chk(5, 4'h0);
    step(1'b1, 1'b0, 1'b1, 8'h90, 32'h7);
    chk(12, {28'h0, irq}, 32'h4);
    rd_chk(12, 8'h80, 32'h8000_0002);
    rd_chk(12, 8'h90, 32'h0000_0007);
    tick_chk(12, 4'h0);
    tick_chk(12, 4'b0100);
    rd_chk(12, 8'h80, 32'h0000_0007);
    step(1'b1, 1'b0, 1'b0, 8'h90, 32'h8000_0007);

    // R11 zero reload value on channel 3
    tick_chk(11, 4'h0);
    tick_chk(11, 4'h0);
    rd_chk(11, 8'hC0, 32'h0);
    step(1'b1, 1'b0, 1'b0, 8'hD0, 32'h2);
    tick_chk(8, 4'h0);
    step(1'b1, 1'b0, 1'b0, 8'hD0, 32'h0);
    tick_chk(11, 4'h0);
    tick_chk(11, 4'h0);
    rd_chk(11, 8'hC0, 32'h0);
    tick_chk(11, 4'h0);
    rd_chk(11, 8'hC0, 32'h0);

    // R13 other channels untouched by all of the above
    rd_chk(13, 8'h00, 32'h8000_0004);
    rd_chk(13, 8'h40, 32'h0000_0002);
    rd_chk(3, 8'h50, 32'h8000_0002);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule